// File: doc/BRIEF.md
# Coil Command Queue with Low-Water and Overflow Interrupt

This block is a small first-in-first-out store for byte-wide commands. It sits between a serial receive path and a downstream modulator. The serial side pushes 8-bit words at its full transfer rate. The modulator pulls them in arrival order through a valid/ready read port. A write pointer, a read pointer and a fill count track the sixteen stored words.

The block raises one interrupt line for two causes. The first is when draining drops the fill level below a quarter of capacity. The second is when a write arrives with every slot taken. Two sticky status bits tell the causes apart. A one-cycle acknowledge pulse clears both bits.

A synchronous wake input returns the queue to empty. It is used when the host powers the coil driver back up. Writes may continue while the consumer is draining, so the host can top the queue up at any time.

Top module: `coil_cmd_queue`

## Requirements
- R1: After asynchronous reset (rst_n low), `fill` is 0, and `rd_valid`, `irq`, `stat_low` and `stat_ovf` are all 0.
- R2: The queue holds up to 16 words of 8 bits each. Words leave on `rd_data` in exactly the order they were written, and `fill` never exceeds 16.
- R3: A clock edge with both an accepted write and an accepted read (`rd_valid && rd_ready`) performs both operations and leaves `fill` unchanged.
- R4: `rd_valid` is 1 exactly when `fill` is nonzero. A read request while empty is ignored: `fill` stays 0 and `rd_valid` stays 0.
- R5: A write with `fill` equal to 16 is discarded, even if a read is accepted in the same cycle. It changes neither the stored words nor their order, and it sets `stat_ovf` on the following cycle.
- R6: `stat_low` is set on the cycle after an accepted read takes `fill` from 4 to 3. It is not set when a write is accepted in the same cycle, nor by any other fill transition, nor by reset.
- R7: `irq` is 1 exactly when at least one of `stat_low` and `stat_ovf` is 1.
- R8: A cycle with `irq_ack` high clears both status bits on the next edge. A cause that occurs in the same cycle as the acknowledge leaves its own bit set.
- R9: A cycle with `wake` high empties the queue on that edge and clears both status bits. Any write or read requested in that cycle is ignored. Words written afterwards come out starting with the first of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | Synchronous clear to empty on wake-up |
| wr_en | input | 1 | Write request from the serial side |
| wr_data | input | 8 | Command word to store |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_valid | output | 1 | Head word is present |
| rd_data | output | 8 | Head word |
| fill | output | 5 | Number of stored words |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | One-cycle acknowledge, clears status bits |
| stat_low | output | 1 | Sticky: low-water crossing seen |
| stat_ovf | output | 1 | Sticky: overflow write seen |

## Verification
Directed bursts fill the queue to 16 and push one more word. This separates a discarded overflow from one that wraps over the head word and corrupts the order. Draining from 5 down to 0 shows whether the low-water bit fires only on the 4-to-3 step. A read and a write at fill 4 show that a balanced cycle does not count as a crossing. Random traffic with rare wake and acknowledge pulses covers pointer wrap, combined read and write at every fill level, and an acknowledge that coincides with a new cause. Each output is compared against a queue model in the bench.

// File: rtl/coil_cmd_pkg.sv
package coil_cmd_pkg;

  // Low-water crossing: a read leaves the count one below the mark.
  function automatic logic low_crossing(input int unsigned cnt,
                                        input int unsigned mark,
                                        input logic pop, input logic push);
    return pop && !push && (cnt == mark);
  endfunction

  // Count after one edge given push and pop.
  function automatic int unsigned count_after(input int unsigned cnt,
                                              input logic push, input logic pop);
    int unsigned n;
    n = cnt;
    if (push && !pop) n = cnt + 1;
    if (pop && !push) n = cnt - 1;
    return n;
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned ptr_after(input int unsigned ptr,
                                            input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/ccq_store.sv
module ccq_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ccq_ctrl.sv
module ccq_ctrl
  import coil_cmd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LOW_MARK = DEPTH / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          push,
  output logic          pop,
  output logic          ovf_evt,
  output logic          low_evt,
  output logic          valid,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count
);
  logic full;

  assign full    = (count == CW'(DEPTH));
  assign valid   = (count != '0);
  assign push    = wr_req && !full && !wake;
  assign pop     = rd_req && valid && !wake;
  assign ovf_evt = wr_req && full && !wake;
  assign low_evt = low_crossing(int'(count), LOW_MARK, pop, push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (wake) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= AW'(ptr_after(int'(wptr), DEPTH));
      if (pop)  rptr <= AW'(ptr_after(int'(rptr), DEPTH));
      count <= CW'(count_after(int'(count), push, pop));
    end
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_rw_keeps_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(count));

  assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && rd_req && !wr_req |=> (count == '0));

  assert_ovf_keeps_wptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> $stable(wptr));

  assert_wake_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (count == '0) && (wptr == rptr));
endmodule

// File: rtl/ccq_irq.sv
module ccq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic low_evt,
  input  logic ovf_evt,
  input  logic ack,
  output logic stat_low,
  output logic stat_ovf,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_low <= 1'b0;
      stat_ovf <= 1'b0;
    end else if (wake) begin
      stat_low <= 1'b0;
      stat_ovf <= 1'b0;
    end else begin
      stat_low <= (stat_low && !ack) || low_evt;
      stat_ovf <= (stat_ovf && !ack) || ovf_evt;
    end
  end

  assign irq = stat_low || stat_ovf;

  assert_low_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |=> stat_low);

  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_ovf);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !low_evt && !ovf_evt |=> !irq);
endmodule

// File: rtl/coil_cmd_queue.sv
module coil_cmd_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    fill,
  output logic             irq,
  input  logic             irq_ack,
  output logic             stat_low,
  output logic             stat_ovf
);
  logic          push_w, pop_w, ovf_evt_w, low_evt_w;
  logic [AW-1:0] wptr_w, rptr_w;

  ccq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wake(wake),
    .wr_req(wr_en), .rd_req(rd_ready),
    .push(push_w), .pop(pop_w), .ovf_evt(ovf_evt_w), .low_evt(low_evt_w),
    .valid(rd_valid), .wptr(wptr_w), .rptr(rptr_w), .count(fill)
  );

  ccq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_w), .waddr(wptr_w), .wdata(wr_data),
    .raddr(rptr_w), .rdata(rd_data)
  );

  ccq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wake(wake),
    .low_evt(low_evt_w), .ovf_evt(ovf_evt_w), .ack(irq_ack),
    .stat_low(stat_low), .stat_ovf(stat_ovf), .irq(irq)
  );

  assert_valid_tracks_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (fill != '0));

  assert_irq_from_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_low || stat_ovf));
endmodule

// File: tb/test_coil_cmd_queue.sv
`timescale 1ns/1ps
module test_coil_cmd_queue;
  localparam int D = 16;

  logic clk = 0, rst_n = 0, wake = 0, wr_en = 0, rd_ready = 0, irq_ack = 0;
  logic [7:0] wr_data = 0;
  logic rd_valid, irq, stat_low, stat_ovf;
  logic [7:0] rd_data;
  logic [4:0] fill;

  always #2.5 clk = ~clk;

  coil_cmd_queue i_coil_cmd_queue (
    .clk(clk), .rst_n(rst_n), .wake(wake), .wr_en(wr_en), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .fill(fill),
    .irq(irq), .irq_ack(irq_ack), .stat_low(stat_low), .stat_ovf(stat_ovf)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] q [D];
  int head = 0, cnt = 0;
  logic m_low = 0, m_ovf = 0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wrap(input int p);
    return p % D;
  endfunction

  // Bench model of one edge, from the requirements.
  task automatic model_edge(input logic wk, input logic w, input logic [7:0] wd,
                            input logic r, input logic ak);
    logic push, pop, ovf, low;
    if (wk) begin
      head = 0; cnt = 0; m_low = 0; m_ovf = 0;
      return;
    end
    push = w && (cnt < D);
    ovf  = w && (cnt == D);
    pop  = r && (cnt > 0);
    low  = pop && !push && (cnt == D / 4);
    if (push) q[wrap(head + cnt)] = wd;
    if (pop) head = wrap(head + 1);
    cnt = cnt + (push ? 1 : 0) - (pop ? 1 : 0);
    m_low = (m_low && !ak) || low;
    m_ovf = (m_ovf && !ak) || ovf;
  endtask

  task automatic compare_all();
    check("R2 fill", int'(fill), cnt);
    check("R4 rd_valid", int'(rd_valid), (cnt != 0) ? 1 : 0);
    if (cnt != 0) check("R2 order", int'(rd_data), int'(q[head]));
    check("R6 stat_low", int'(stat_low), int'(m_low));
    check("R5 stat_ovf", int'(stat_ovf), int'(m_ovf));
    check("R7 irq", int'(irq), int'(m_low || m_ovf));
  endtask

  task automatic step(input logic wk, input logic w, input logic [7:0] wd,
                      input logic r, input logic ak);
    wake = wk; wr_en = w; wr_data = wd; rd_ready = r; irq_ack = ak;
    model_edge(wk, w, wd, r, ak);
    @(posedge clk); #1;
    wake = 0; wr_en = 0; rd_ready = 0; irq_ack = 0;
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    #12;
    // R1: reset state
    check("R1 fill", int'(fill), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 status", int'(stat_low) + int'(stat_ovf), 0);
    @(negedge clk); rst_n = 1; #1;

    // R4: read while empty is ignored
    step(0, 0, 0, 1, 0);
    check("R4 empty read fill", int'(fill), 0);

    // R2: fill to 16 in order
    for (int i = 0; i < D; i++) step(0, 1, 8'(8'h30 + i), 0, 0);
    check("R2 full", int'(fill), 16);
    // R5: overflow, also with a read in the same cycle
    step(0, 1, 8'hEE, 0, 0);
    check("R5 ovf set", int'(stat_ovf), 1);
    step(0, 1, 8'hDD, 1, 0);
    check("R5 head after ovf+read", int'(rd_data), 8'h31);
    // R8: acknowledge clears
    step(0, 0, 0, 0, 1);
    check("R8 irq cleared", int'(irq), 0);
    // drain to 5
    while (cnt > 5) step(0, 0, 0, 1, 0);
    // R3/R6: balanced cycle at fill 4 gives no crossing
    step(0, 0, 0, 1, 0);
    step(0, 1, 8'h77, 1, 0);
    check("R6 no crossing on r+w", int'(stat_low), 0);
    // R6: 4->3 crossing
    step(0, 0, 0, 1, 0);
    check("R6 low set", int'(stat_low), 1);
    // R8: ack coinciding with overflow? use low: ack while crossing again
    step(0, 1, 8'h11, 0, 0);
    step(0, 0, 0, 1, 1);
    check("R8 event wins over ack", int'(stat_low), 1);
    step(0, 0, 0, 0, 1);
    // drain fully, further drops below mark give no new crossing
    while (cnt > 0) step(0, 0, 0, 1, 0);
    check("R6 no repeat", int'(stat_low), 0);
    // R9: wake empties, ignores a write, then order restarts
    step(0, 1, 8'hA1, 0, 0);
    step(0, 1, 8'hA2, 0, 0);
    step(1, 1, 8'hA3, 1, 0);
    check("R9 wake empty", int'(fill), 0);
    step(0, 1, 8'hB0, 0, 0);
    check("R9 first after wake", int'(rd_data), 8'hB0);

    // random traffic in phases biased toward filling and draining
    for (int ph = 0; ph < 40; ph++) begin
      int wbias;
      wbias = (ph % 2 == 0) ? 80 : 25;
      for (int k = 0; k < 100; k++) begin
        logic w, r, wk, ak;
        w  = ($urandom % 100) < wbias;
        r  = ($urandom % 100) < (100 - wbias);
        wk = ($urandom % 256) == 0;
        ak = ($urandom % 16) == 0;
        step(wk, w, 8'($urandom), r, ak);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule